// File: doc/BRIEF.md
# Dual-Mode I/Q Sample Capture and Formatter

This block sits at the digital input of a two-channel DAC. It accepts sample words either from one shared 14-bit port, where I and Q words alternate and a select line marks each word's channel, or from two separate ports that deliver an I word and a Q word together. In split-port mode the select line and an auxiliary line are no longer control pins: they carry bits 13 and 12 of the Q word. The capture edge can be the rising or the falling edge of the clock.

Each captured word can be read as two's complement or as offset binary. Offset binary is turned into two's complement by flipping the top bit. Each channel then gets a signed digital offset of up to 1023 LSB, added or subtracted as set by a polarity bit. The result saturates to the 14-bit signed range. The outputs are registered samples, each with a strobe. In shared-port mode only the channel that received a word raises its strobe. The other channel keeps its previous sample.

Top module: `iq_capture_fmt`

## Requirements
- R1: While reset is asserted, both sample outputs are zero and both valid strobes are low.
- R2: In shared-port mode (`cfg_dual`=0), a word on `port_a` with `chan_sel_b13`=1 updates `i_data` and pulses `i_vld` for one cycle, while `q_vld` stays low and `q_data` keeps its value.
- R3: In shared-port mode, a word with `chan_sel_b13`=0 updates `q_data` and pulses `q_vld`, while `i_vld` stays low and `i_data` keeps its value.
- R4: In shared-port mode, `port_b_lo` and `alt_b12` have no effect on either output.
- R5: In split-port mode (`cfg_dual`=1), every captured cycle updates both channels and raises both strobes. I comes from `port_a`. The Q word is `{chan_sel_b13, alt_b12, port_b_lo}`, with `chan_sel_b13` as bit 13.
- R6: With `cfg_offbin`=1, input code 0x0000 reads as -8192, 0x1FFF as -1 and 0x3FFF as +8191, which is the input with bit 13 inverted. With `cfg_offbin`=0, the word is taken as two's complement unchanged.
- R7: Each channel adds its 10-bit offset magnitude (0..1023) when its polarity bit is 1, and subtracts it when the polarity bit is 0. A magnitude of zero leaves the sample unchanged.
- R8: The offset sum saturates at -8192 and +8191.
- R9: With `cfg_fall`=0, a word present at rising edge k appears on the outputs after rising edge k+1. With `cfg_fall`=1, a word is sampled at the falling edge and appears on the outputs after the next rising edge, one cycle sooner.
- R10: After reset is released, no strobe rises until a word has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dual | input | 1 | 0 selects shared-port interleaved input, 1 selects split ports |
| cfg_offbin | input | 1 | 0 selects two's complement input, 1 selects offset binary |
| cfg_fall | input | 1 | 0 captures on the rising edge, 1 on the falling edge |
| off_mag_i | input | 10 | I-channel offset magnitude |
| off_pol_i | input | 1 | I-channel offset polarity (1 adds, 0 subtracts) |
| off_mag_q | input | 10 | Q-channel offset magnitude |
| off_pol_q | input | 1 | Q-channel offset polarity (1 adds, 0 subtracts) |
| port_a | input | 14 | Shared data port, or the I port in split mode |
| port_b_lo | input | 12 | Q word bits 11..0 in split mode |
| chan_sel_b13 | input | 1 | Channel select in shared mode (1 = I), Q bit 13 in split mode |
| alt_b12 | input | 1 | Q bit 12 in split mode, ignored in shared mode |
| i_data | output | 14 | I sample, two's complement |
| i_vld | output | 1 | I sample strobe |
| q_data | output | 14 | Q sample, two's complement |
| q_vld | output | 1 | Q sample strobe |

## Verification
Format conversion and the saturating offset act in the same cycle on the same word. An offset-binary extreme such as 0x3FFF or 0x0000 can therefore be pushed past the rail by the offset. The bench drives these codes with the maximum magnitude in both polarities and expects the clamped value. Channel steering and the capture-edge choice also meet when the edge selection changes during an interleaved stream. At that point one word may be applied twice or skipped. The bench's model tracks the last two captured words and judges each output against whichever word the current edge setting selects.

// File: rtl/iqcf_pkg.sv
package iqcf_pkg;

  typedef enum logic {
    PORT_SHARED = 1'b0,
    PORT_SPLIT  = 1'b1
  } port_mode_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } cap_edge_e;

endpackage

// File: rtl/iqcf_edge_capture.sv
module iqcf_edge_capture #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cap_rise,
  output logic         rise_vld,
  output logic [W-1:0] cap_fall,
  output logic         fall_vld
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rise <= '0;
      rise_vld <= 1'b0;
    end else begin
      cap_rise <= din;
      rise_vld <= 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_fall <= '0;
      fall_vld <= 1'b0;
    end else begin
      cap_fall <= din;
      fall_vld <= 1'b1;
    end
  end

  // R10
  rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise_vld) |-> rise_vld);

endmodule

// File: rtl/iqcf_steer.sv
module iqcf_steer #(
  parameter int DW = 14
) (
  input  logic          split_mode,
  input  logic          word_vld,
  input  logic [DW-1:0] port_a,
  input  logic [DW-3:0] port_b_lo,
  input  logic          sel_b13,
  input  logic          alt_b12,
  output logic [DW-1:0] word_i,
  output logic [DW-1:0] word_q,
  output logic          load_i,
  output logic          load_q
);

  logic [DW-1:0] split_q;

  assign split_q = {sel_b13, alt_b12, port_b_lo};
  assign word_i  = port_a;
  assign word_q  = split_mode ? split_q : port_a;

  always_comb begin
    if (split_mode) begin
      load_i = word_vld;
      load_q = word_vld;
    end else begin
      load_i = word_vld & sel_b13;
      load_q = word_vld & ~sel_b13;
    end
  end

endmodule

// File: rtl/iqcf_chan_proc.sv
module iqcf_chan_proc #(
  parameter int DW = 14,
  parameter int OW = 10
) (
  input  logic [DW-1:0] raw,
  input  logic          offbin,
  input  logic [OW-1:0] mag,
  input  logic          pol,
  output logic [DW-1:0] fmt,
  output logic [DW-1:0] res
);

  localparam int EW   = DW + 2;
  localparam int MAXV = 2 ** (DW - 1) - 1;
  localparam int MINV = -(2 ** (DW - 1));
  localparam logic signed [EW-1:0] HI = EW'(MAXV);
  localparam logic signed [EW-1:0] LO = EW'(MINV);

  function automatic logic [DW-1:0] to_signed_word(input logic [DW-1:0] w,
                                                   input logic ob);
    logic [DW-1:0] r;
    r = w;
    if (ob) r[DW-1] = ~w[DW-1];
    return r;
  endfunction

  function automatic logic [DW-1:0] offset_sat(input logic [DW-1:0] s,
                                               input logic [OW-1:0] m,
                                               input logic up);
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] mm;
    logic signed [EW-1:0] sum;
    ext = EW'($signed(s));
    mm  = EW'(m);
    sum = up ? ext + mm : ext - mm;
    if (sum > HI)      return HI[DW-1:0];
    else if (sum < LO) return LO[DW-1:0];
    else               return sum[DW-1:0];
  endfunction

  assign fmt = to_signed_word(raw, offbin);
  assign res = offset_sat(fmt, mag, pol);

  always_comb begin
    // R7
    if (pol) begin
      offs_up_chk: assert ($signed(res) >= $signed(fmt));
    end else begin
      offs_down_chk: assert ($signed(res) <= $signed(fmt));
    end
    // R7
    if (mag == '0) begin
      offs_zero_chk: assert (res == fmt);
    end
  end

endmodule

// File: rtl/iq_capture_fmt.sv
module iq_capture_fmt #(
  parameter int DW = 14,
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dual,
  input  logic          cfg_offbin,
  input  logic          cfg_fall,
  input  logic [OW-1:0] off_mag_i,
  input  logic          off_pol_i,
  input  logic [OW-1:0] off_mag_q,
  input  logic          off_pol_q,
  input  logic [DW-1:0] port_a,
  input  logic [DW-3:0] port_b_lo,
  input  logic          chan_sel_b13,
  input  logic          alt_b12,
  output logic [DW-1:0] i_data,
  output logic          i_vld,
  output logic [DW-1:0] q_data,
  output logic          q_vld
);
  import iqcf_pkg::*;

  localparam int CW = 2 * DW;
  localparam int NCH = 2;

  port_mode_e mode;
  cap_edge_e  edge_sel;
  assign mode     = port_mode_e'(cfg_dual);
  assign edge_sel = cap_edge_e'(cfg_fall);

  logic [CW-1:0] din, cap_r, cap_f, stage;
  logic          vld_r, vld_f, stage_vld;

  assign din = {chan_sel_b13, alt_b12, port_b_lo, port_a};

  iqcf_edge_capture #(.W(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .din(din),
    .cap_rise(cap_r), .rise_vld(vld_r),
    .cap_fall(cap_f), .fall_vld(vld_f)
  );

  assign stage     = (edge_sel == EDGE_FALL) ? cap_f : cap_r;
  assign stage_vld = (edge_sel == EDGE_FALL) ? vld_f : vld_r;

  logic [DW-1:0] word_i, word_q;
  logic          load_i, load_q;

  iqcf_steer #(.DW(DW)) u_steer (
    .split_mode(mode == PORT_SPLIT),
    .word_vld(stage_vld),
    .port_a(stage[DW-1:0]),
    .port_b_lo(stage[2*DW-3:DW]),
    .sel_b13(stage[CW-1]),
    .alt_b12(stage[CW-2]),
    .word_i(word_i), .word_q(word_q),
    .load_i(load_i), .load_q(load_q)
  );

  logic [DW-1:0] raw_w [NCH];
  logic [OW-1:0] mag_w [NCH];
  logic          pol_w [NCH];
  logic          ld_w  [NCH];
  logic [DW-1:0] fmt_w [NCH];
  logic [DW-1:0] res_w [NCH];
  logic [DW-1:0] dat_q [NCH];
  logic          vld_q [NCH];

  assign raw_w[0] = word_i;
  assign raw_w[1] = word_q;
  assign mag_w[0] = off_mag_i;
  assign mag_w[1] = off_mag_q;
  assign pol_w[0] = off_pol_i;
  assign pol_w[1] = off_pol_q;
  assign ld_w[0]  = load_i;
  assign ld_w[1]  = load_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    iqcf_chan_proc #(.DW(DW), .OW(OW)) u_proc (
      .raw(raw_w[c]), .offbin(cfg_offbin),
      .mag(mag_w[c]), .pol(pol_w[c]),
      .fmt(fmt_w[c]), .res(res_w[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[c] <= '0;
        vld_q[c] <= 1'b0;
      end else begin
        vld_q[c] <= ld_w[c];
        if (ld_w[c]) dat_q[c] <= res_w[c];
      end
    end
  end

  assign i_data = dat_q[0];
  assign i_vld  = vld_q[0];
  assign q_data = dat_q[1];
  assign q_vld  = vld_q[1];

  // R2 R3
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_dual) |-> $onehot0({i_vld, q_vld}));

  // R2
  i_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !i_vld |-> $stable(i_data));

  // R3
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld |-> $stable(q_data));

  // R5
  split_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_dual) |-> (i_vld == q_vld));

endmodule

// File: tb/test_iq_capture_fmt.sv
module test_iq_capture_fmt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dual = 0, cfg_offbin = 0, cfg_fall = 0;
  logic [9:0]  off_mag_i = '0, off_mag_q = '0;
  logic        off_pol_i = 0, off_pol_q = 0;
  logic [13:0] port_a = '0;
  logic [11:0] port_b_lo = '0;
  logic        chan_sel_b13 = 0, alt_b12 = 0;
  logic [13:0] i_data, q_data;
  logic        i_vld, q_vld;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  iq_capture_fmt i_iq_capture_fmt (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_offbin(cfg_offbin),
    .cfg_fall(cfg_fall), .off_mag_i(off_mag_i), .off_pol_i(off_pol_i),
    .off_mag_q(off_mag_q), .off_pol_q(off_pol_q), .port_a(port_a),
    .port_b_lo(port_b_lo), .chan_sel_b13(chan_sel_b13), .alt_b12(alt_b12),
    .i_data(i_data), .i_vld(i_vld), .q_data(q_data), .q_vld(q_vld)
  );

  // history of driven words: h1 = one cycle ago, h2 = two cycles ago
  logic [13:0] a_h1, a_h2;
  logic [11:0] b_h1, b_h2;
  bit s_h1, s_h2, x_h1, x_h2, v_h1 = 0, v_h2 = 0;
  int exp_i = 0, exp_q = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench view of the arithmetic: signed interpretation, offset, clamp
  function automatic int bexp(input logic [13:0] w, input bit ob,
                              input logic [9:0] m, input bit up,
                              output bit clamped);
    int v;
    v = int'(w);
    if (ob) v = v - 8192;
    else if (v >= 8192) v = v - 16384;
    v = up ? v + int'(m) : v - int'(m);
    clamped = 0;
    if (v > 8191) begin v = 8191; clamped = 1; end
    if (v < -8192) begin v = -8192; clamped = 1; end
    return v;
  endfunction

  task automatic check_edge();
    logic [13:0] a; logic [11:0] b; bit s, x, v, ci, cq;
    bit ei, eq;
    string tg, rest;
    a = cfg_fall ? a_h1 : a_h2;
    b = cfg_fall ? b_h1 : b_h2;
    s = cfg_fall ? s_h1 : s_h2;
    x = cfg_fall ? x_h1 : x_h2;
    v = cfg_fall ? v_h1 : v_h2;
    ci = 0; cq = 0; ei = 0; eq = 0;
    if (v) begin
      if (cfg_dual) begin
        exp_i = bexp(a, cfg_offbin, off_mag_i, off_pol_i, ci);
        exp_q = bexp({s, x, b}, cfg_offbin, off_mag_q, off_pol_q, cq);
        ei = 1; eq = 1;
      end else if (s) begin
        exp_i = bexp(a, cfg_offbin, off_mag_i, off_pol_i, ci);
        ei = 1;
      end else begin
        exp_q = bexp(a, cfg_offbin, off_mag_q, off_pol_q, cq);
        eq = 1;
      end
    end
    rest = {cfg_offbin ? " R6" : "", " R7", cfg_fall ? " R9" : ""};
    tg = cfg_dual ? "R5" : (v ? "R2 R3" : "R10");
    chk({tg, " i_vld"}, int'(i_vld), int'(ei));
    chk({tg, " q_vld"}, int'(q_vld), int'(eq));
    tg = cfg_dual ? "R5" : (ei ? "R2" : "R3 R4");
    chk({tg, rest, ci ? " R8" : "", " i_data"}, int'($signed(i_data)), exp_i);
    tg = cfg_dual ? "R5" : (eq ? "R3" : "R2 R4");
    chk({tg, rest, cq ? " R8" : "", " q_data"}, int'($signed(q_data)), exp_q);
  endtask

  task automatic push_word(input logic [13:0] a, input logic [11:0] b,
                           input bit s, input bit x);
    a_h2 = a_h1; b_h2 = b_h1; s_h2 = s_h1; x_h2 = x_h1; v_h2 = v_h1;
    a_h1 = a; b_h1 = b; s_h1 = s; x_h1 = x; v_h1 = 1;
    port_a = a; port_b_lo = b; chan_sel_b13 = s; alt_b12 = x;
  endtask

  task automatic cyc(input logic [13:0] a, input logic [11:0] b,
                     input bit s, input bit x);
    @(posedge clk); #5;
    check_edge();
    push_word(a, b, s, x);
  endtask

  task automatic rand_cyc();
    cyc(14'($urandom), 12'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #5;
    // R1
    chk("R1 i_vld", int'(i_vld), 0);
    chk("R1 q_vld", int'(q_vld), 0);
    chk("R1 i_data", int'(i_data), 0);
    chk("R1 q_data", int'(q_data), 0);
    rst_n = 1'b1;
    push_word('0, '0, 1'b0, 1'b0);

    // directed: shared mode, two's complement, saturation both rails (R8)
    off_pol_i = 1; off_mag_i = 10'd1023;
    off_pol_q = 0; off_mag_q = 10'd1023;
    cyc(14'h1FFF, 12'hFFF, 1, 1);
    cyc(14'h2000, 12'h000, 0, 0);
    cyc(14'h0005, 12'hABC, 1, 1);
    cyc(14'h3FFF, 12'h123, 0, 1);
    // offset binary extremes with zero offset (R6)
    cfg_offbin = 1; off_mag_i = '0; off_mag_q = '0;
    cyc(14'h0000, 12'h555, 1, 0);
    cyc(14'h3FFF, 12'hAAA, 0, 1);
    cyc(14'h1FFF, 12'h000, 1, 1);
    cyc(14'h2000, 12'hFFF, 0, 0);
    // offset binary extremes pushed past the rails (R6 R8)
    off_pol_i = 1; off_mag_i = 10'd1023; off_pol_q = 0; off_mag_q = 10'd1023;
    cyc(14'h3FFF, 12'h0, 1, 0);
    cyc(14'h0000, 12'h0, 0, 0);
    cyc(14'h3F00, 12'h0, 1, 0);
    // falling edge capture, then split ports (R9 R5)
    cfg_fall = 1;
    repeat (6) rand_cyc();
    cfg_dual = 1;
    repeat (6) rand_cyc();
    cfg_fall = 0;
    repeat (6) rand_cyc();

    // constrained random segments
    for (int seg = 0; seg < 16; seg++) begin
      cfg_dual   = 1'($urandom);
      cfg_offbin = 1'($urandom);
      cfg_fall   = 1'($urandom);
      off_pol_i  = 1'($urandom);
      off_pol_q  = 1'($urandom);
      off_mag_i  = (seg % 4 == 0) ? 10'd0 : 10'($urandom);
      off_mag_q  = (seg % 5 == 0) ? 10'd1023 : 10'($urandom);
      for (int k = 0; k < 40; k++) rand_cyc();
    end
    @(posedge clk); #5;
    check_edge();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule